// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator Aggregator

This block gathers the latched events of every hot-plug slot, together with a command-completion flag, into one 32-bit locator word and one interrupt output. Each slot owns an event latch, where slot-side logic sets bits with one-cycle pulses and software clears them by writing ones. Each slot also owns a mask byte whose bits keep individual events away from the interrupt. A global control word holds the interrupt disable, the command-interrupt disable and the sticky command-detected flag.

Register decode lives in a neighbouring block. That block presents a slot index, a data byte and separate write enables for the latch and the mask, plus a full-word write for the global control word. It reads all state back through the flat read-back ports. The locator is rebuilt combinationally every cycle from the registered state. The level interrupt follows it directly. A message request pulses for a single clock only when the level rises relative to the level tracked on the previous cycle.

Top module: `hp_irq_locator`

## Requirements
- R1: After reset every event latch reads 0x00, every mask byte reads 0x7F, the global word reads 0x00000001 (interrupt disabled), and locator, irq_level and msi_req are 0.
- R2: A pulse on a slot's event-set bit k (k in 0..4: presence, isolated fault, button, retention latch, connected fault) sets latch bit k at the next edge. A set and a write-one-clear of the same bit in one cycle leave the bit set.
- R3: A latch write clears each of bits 0..4 that is written as 1 and leaves bits written as 0 unchanged. Latch bits 5..7 always read 0.
- R4: A mask write loads bits 0..6 from the data byte. Bit 7 reads 0. Mask bits 5 and 6 are error-signalling disables only.
- R5: Locator bit s+1 is 1 exactly when slot s has any latch bit 0..4 set whose mask bit is clear. Mask bits 5 and 6 never affect it, and locator bits above NSLOT are 0.
- R6: A cmd_done pulse sets global bit 16 (command detected). A global write loads bits 0..3 from the data and clears bit 16 where the data has a 1. When a set and a clear of bit 16 fall in the same cycle, the set wins. All other global bits read 0.
- R7: Locator bit 0 is 1 exactly when global bit 16 is 1 and global bit 2 (command-interrupt disable) is 0.
- R8: irq_level is 1 exactly when global bit 0 (interrupt disable) is 0 and the locator is nonzero.
- R9: A tracked level follows irq_level every cycle, whether or not messages are enabled, and resets to 0. msi_req is 1 for one cycle when msi_en is 1, irq_level is 1 and the tracked level is 0. It is never 1 on a falling level.
- R10: Latch and mask writes whose slot index is NSLOT or greater change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| evt_set | input | NSLOT*5 | Event-set pulses, 5 bits per slot, slot s at [5s +: 5] |
| cmd_done | input | 1 | Command completion pulse |
| slot_idx | input | 5 | Slot addressed by a latch or mask write |
| wr_data | input | 8 | Data byte for latch or mask writes |
| lat_we | input | 1 | Write-one-to-clear to the addressed event latch |
| msk_we | input | 1 | Write to the addressed mask byte |
| glb_we | input | 1 | Write to the global control word |
| glb_wdata | input | 32 | Data for the global control word |
| latch_q | output | NSLOT*8 | Event latches, slot s at [8s +: 8] |
| mask_q | output | NSLOT*8 | Mask bytes, slot s at [8s +: 8] |
| glb_q | output | 32 | Global control word |
| locator | output | 32 | Interrupt locator |
| irq_level | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message request |

## Verification
The bench builds the block with NSLOT set to 4. This keeps the slot space small enough to sweep every pairing of the 32 latch patterns with the 128 mask values on one slot, and to check the locator and the level on each pairing. Four slots also leave slot indices 4 through 31 free to address, so writes to nonexistent slots can be shown to be harmless. The high locator bits that no slot drives stay observable as zero.

// File: rtl/hpl_pkg.sv
package hpl_pkg;
  localparam int EVW       = 5;   // event bits per slot
  localparam int IDXW      = 5;   // slot index width (up to 31 slots)
  localparam int LOCW      = 32;  // locator width
  localparam logic [7:0] EV_MASK   = 8'h1F;
  localparam logic [7:0] MSK_MASK  = 8'h7F;
  localparam int G_INT_DIS     = 0;
  localparam int G_CMD_INT_DIS = 2;
  localparam int G_CMD_DET     = 16;
  localparam logic [31:0] G_WMASK = 32'h0000_000F;
  localparam logic [31:0] G_W1C   = 32'h0003_0000;
  localparam logic [31:0] G_RESET = 32'h0000_0001;

  function automatic logic slot_pending(logic [7:0] lat, logic [7:0] msk);
    return |(lat & ~msk & EV_MASK);
  endfunction

  function automatic logic cmd_pending(logic [31:0] g);
    return g[G_CMD_DET] & ~g[G_CMD_INT_DIS];
  endfunction

  function automatic logic level_of(logic [31:0] g, logic [LOCW-1:0] loc);
    return ~g[G_INT_DIS] & (|loc);
  endfunction
endpackage

// File: rtl/hpl_slot_regs.sv
module hpl_slot_regs
  import hpl_pkg::*;
#(
  parameter int NSLOT = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT*EVW-1:0]  evt_set,
  input  logic [IDXW-1:0]       slot_idx,
  input  logic [7:0]            wr_data,
  input  logic                  lat_we,
  input  logic                  msk_we,
  output logic [NSLOT*8-1:0]    latch_q,
  output logic [NSLOT*8-1:0]    mask_q,
  output logic [NSLOT-1:0]      slot_pend
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic       hit;
    logic [7:0] lat_r, msk_r, lat_n, clr;
    assign hit   = (slot_idx == IDXW'(s));
    assign clr   = (hit && lat_we) ? wr_data : 8'h00;
    // set wins over a same-cycle clear
    assign lat_n = ((lat_r & ~clr) | {3'b000, evt_set[s*EVW +: EVW]}) & EV_MASK;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_r <= 8'h00;
        msk_r <= MSK_MASK;
      end else begin
        lat_r <= lat_n;
        if (hit && msk_we) msk_r <= wr_data & MSK_MASK;
      end
    end

    assign latch_q[s*8 +: 8] = lat_r;
    assign mask_q[s*8 +: 8]  = msk_r;
    assign slot_pend[s]      = slot_pending(lat_r, msk_r);
  end
endmodule

// File: rtl/hpl_global_ctrl.sv
module hpl_global_ctrl
  import hpl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        glb_we,
  input  logic [31:0] glb_wdata,
  input  logic        cmd_done,
  output logic [31:0] glb_q,
  output logic        cmd_pend
);
  logic [31:0] g_r, g_n, wr_val, set_val;

  always_comb begin
    wr_val = g_r;
    if (glb_we) begin
      wr_val = (g_r & ~G_WMASK) | (glb_wdata & G_WMASK);
      wr_val = wr_val & ~(glb_wdata & G_W1C);
    end
    set_val = 32'(cmd_done) << G_CMD_DET;
    g_n     = (wr_val | set_val) & (G_WMASK | G_W1C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) g_r <= G_RESET;
    else        g_r <= g_n;
  end

  assign glb_q    = g_r;
  assign cmd_pend = cmd_pending(g_r);
endmodule

// File: rtl/hpl_irq_gen.sv
module hpl_irq_gen
  import hpl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msi_en,
  input  logic [31:0]     glb_q,
  input  logic [LOCW-1:0] locator,
  output logic            irq_level,
  output logic            lvl_prev,
  output logic            msi_req
);
  assign irq_level = level_of(glb_q, locator);

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= irq_level;
  end

  assign msi_req = msi_en & irq_level & ~lvl_prev;
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
  import hpl_pkg::*;
#(
  parameter int NSLOT = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msi_en,
  input  logic [NSLOT*5-1:0]    evt_set,
  input  logic                  cmd_done,
  input  logic [4:0]            slot_idx,
  input  logic [7:0]            wr_data,
  input  logic                  lat_we,
  input  logic                  msk_we,
  input  logic                  glb_we,
  input  logic [31:0]           glb_wdata,
  output logic [NSLOT*8-1:0]    latch_q,
  output logic [NSLOT*8-1:0]    mask_q,
  output logic [31:0]           glb_q,
  output logic [31:0]           locator,
  output logic                  irq_level,
  output logic                  msi_req
);
  logic [NSLOT-1:0] slot_pend;
  logic             cmd_pend;
  logic             lvl_prev;

  hpl_slot_regs #(.NSLOT(NSLOT)) u_slots (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .slot_idx(slot_idx),
    .wr_data(wr_data), .lat_we(lat_we), .msk_we(msk_we),
    .latch_q(latch_q), .mask_q(mask_q), .slot_pend(slot_pend)
  );

  hpl_global_ctrl u_glb (
    .clk(clk), .rst_n(rst_n), .glb_we(glb_we), .glb_wdata(glb_wdata),
    .cmd_done(cmd_done), .glb_q(glb_q), .cmd_pend(cmd_pend)
  );

  for (genvar b = 0; b < LOCW; b++) begin : g_loc
    if (b == 0) begin : g_cmd
      assign locator[b] = cmd_pend;
    end else if (b <= NSLOT) begin : g_slot
      assign locator[b] = slot_pend[b-1];
    end else begin : g_none
      assign locator[b] = 1'b0;
    end
  end

  hpl_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .glb_q(glb_q),
    .locator(locator), .irq_level(irq_level), .lvl_prev(lvl_prev),
    .msi_req(msi_req)
  );
endmodule

// File: rtl/hp_irq_locator_chk.sv
module hp_irq_locator_chk #(
  parameter int NSLOT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_en,
  input logic [4:0]        evt_set0,
  input logic [7:0]        latch0,
  input logic [31:0]       glb_q,
  input logic [31:0]       locator,
  input logic              irq_level,
  input logic              lvl_prev,
  input logic              msi_req
);
  // R2: an event pulse on slot 0 is latched at the next edge
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set0 != 5'd0) |=> ((latch0[4:0] & $past(evt_set0)) == $past(evt_set0)));

  // R7: command locator bit only with command detected
  a_r7_cmd_bit: assert property (@(posedge clk) disable iff (!rst_n)
    locator[0] |-> (glb_q[16] && !glb_q[2]));

  // R8: level matches disable bit and locator
  a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == (!glb_q[0] && (locator != 32'd0)));

  // R9: tracker follows level
  a_r9_tracker: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_prev == $past(irq_level)));

  // R9: message request lasts one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  // R9: request needs enable and high level
  a_r9_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> (msi_en && irq_level));

  // R9: no request on a falling level
  a_r9_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_level) |-> !msi_req);

  // R5: locator bits above the last slot stay clear
  if (NSLOT < 31) begin : g_upper
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (locator >> (NSLOT + 1)) == 32'd0);
  end
endmodule

bind hp_irq_locator hp_irq_locator_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .evt_set0(evt_set[4:0]),
  .latch0(latch_q[7:0]), .glb_q(glb_q), .locator(locator),
  .irq_level(irq_level), .lvl_prev(lvl_prev), .msi_req(msi_req)
);

// File: tb/test_hp_irq_locator.sv
module test_hp_irq_locator;
  localparam int NS = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            msi_en = 1'b0;
  logic [NS*5-1:0] evt_set = '0;
  logic            cmd_done = 1'b0;
  logic [4:0]      slot_idx = '0;
  logic [7:0]      wr_data = '0;
  logic            lat_we = 1'b0, msk_we = 1'b0, glb_we = 1'b0;
  logic [31:0]     glb_wdata = '0;
  logic [NS*8-1:0] latch_q, mask_q;
  logic [31:0]     glb_q, locator;
  logic            irq_level, msi_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hp_irq_locator #(.NSLOT(NS)) i_hp_irq_locator (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .evt_set(evt_set),
    .cmd_done(cmd_done), .slot_idx(slot_idx), .wr_data(wr_data),
    .lat_we(lat_we), .msk_we(msk_we), .glb_we(glb_we), .glb_wdata(glb_wdata),
    .latch_q(latch_q), .mask_q(mask_q), .glb_q(glb_q), .locator(locator),
    .irq_level(irq_level), .msi_req(msi_req)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_lat(int s, logic [7:0] d);
    slot_idx = 5'(s); wr_data = d; lat_we = 1'b1;
    step();
    lat_we = 1'b0;
  endtask

  task automatic wr_msk(int s, logic [7:0] d);
    slot_idx = 5'(s); wr_data = d; msk_we = 1'b1;
    step();
    msk_we = 1'b0;
  endtask

  task automatic wr_glb(logic [31:0] d);
    glb_wdata = d; glb_we = 1'b1;
    step();
    glb_we = 1'b0;
  endtask

  task automatic set_evt(int s, logic [4:0] e);
    evt_set[s*5 +: 5] = e;
    step();
    evt_set = '0;
  endtask

  function automatic logic [7:0] lat_of(int s);
    return latch_q[s*8 +: 8];
  endfunction

  function automatic logic [7:0] msk_of(int s);
    return mask_q[s*8 +: 8];
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_loc;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int s = 0; s < NS; s++) begin
      chk("R1 latch", 32'(lat_of(s)), 32'h00);
      chk("R1 mask", 32'(msk_of(s)), 32'h7F);
    end
    chk("R1 glb", glb_q, 32'h1);
    chk("R1 locator", locator, 32'h0);
    chk("R1 level", 32'(irq_level), 32'h0);
    chk("R1 msi", 32'(msi_req), 32'h0);

    // R2 event set
    set_evt(2, 5'h15);
    chk("R2 set", 32'(lat_of(2)), 32'h15);
    evt_set[2*5 +: 5] = 5'h01;
    wr_lat(2, 8'h01);
    evt_set = '0;
    chk("R2 set wins", 32'(lat_of(2)), 32'h15);

    // R3 write-one-to-clear
    wr_lat(2, 8'h04);
    chk("R3 clear one", 32'(lat_of(2)), 32'h11);
    wr_lat(2, 8'h00);
    chk("R3 zero keeps", 32'(lat_of(2)), 32'h11);
    set_evt(2, 5'h1F);
    wr_lat(2, 8'hE0);
    chk("R3 high bits", 32'(lat_of(2)), 32'h1F);
    wr_lat(2, 8'hFF);
    chk("R3 clear all", 32'(lat_of(2)), 32'h00);

    // R4 mask write
    for (int v = 0; v < 256; v += 17) begin
      wr_msk(3, 8'(v));
      chk("R4 mask", 32'(msk_of(3)), 32'(v & 8'h7F));
    end
    wr_msk(3, 8'h7F);

    // R5 / R8 exhaustive sweep on slot 1, interrupt enabled
    wr_glb(32'h0);
    chk("R8 disable cleared", glb_q, 32'h0);
    for (int m = 0; m < 128; m++) begin
      wr_msk(1, 8'(m));
      for (int e = 0; e < 32; e++) begin
        wr_lat(1, 8'hFF);
        set_evt(1, 5'(e));
        exp_loc = ((e & ~m & 32'h1F) != 0) ? 32'h4 : 32'h0;
        chk("R5 sweep locator", locator, exp_loc);
        chk("R8 sweep level", 32'(irq_level), 32'(exp_loc != 0));
      end
    end
    wr_lat(1, 8'hFF);
    wr_msk(1, 8'h7F);

    // R5 each slot maps to bit s+1
    for (int s = 0; s < NS; s++) begin
      wr_msk(s, 8'h60);
      set_evt(s, 5'h01);
      chk("R5 slot bit", locator, 32'h1 << (s + 1));
      wr_lat(s, 8'h1F);
      wr_msk(s, 8'h7F);
    end

    // R6 / R7 command detected
    cmd_done = 1'b1; step(); cmd_done = 1'b0;
    chk("R6 cmd set", glb_q, 32'h0001_0000);
    chk("R7 cmd bit", locator, 32'h1);
    chk("R8 cmd level", 32'(irq_level), 32'h1);
    wr_glb(32'h0000_0004);
    chk("R7 cmd masked", locator, 32'h0);
    chk("R6 kept", glb_q, 32'h0001_0004);
    cmd_done = 1'b1; glb_wdata = 32'h0001_0004; glb_we = 1'b1;
    step();
    cmd_done = 1'b0; glb_we = 1'b0;
    chk("R6 set wins", glb_q, 32'h0001_0004);
    wr_glb(32'hFFFF_FFFF);
    chk("R6 all ones", glb_q, 32'h0000_000F);
    chk("R8 disabled", 32'(irq_level), 32'h0);
    wr_glb(32'h0);

    // R9 message requests
    msi_en = 1'b1;
    wr_msk(0, 8'h00);
    chk("R9 idle", 32'(msi_req), 32'h0);
    set_evt(0, 5'h02);
    chk("R9 rise pulse", 32'(msi_req), 32'h1);
    step();
    chk("R9 one cycle", 32'(msi_req), 32'h0);
    chk("R9 level held", 32'(irq_level), 32'h1);
    wr_lat(0, 8'h02);
    chk("R9 fall level", 32'(irq_level), 32'h0);
    chk("R9 no fall pulse", 32'(msi_req), 32'h0);
    msi_en = 1'b0;
    set_evt(0, 5'h02);
    chk("R9 disabled no pulse", 32'(msi_req), 32'h0);
    msi_en = 1'b1;
    step();
    chk("R9 tracker followed", 32'(msi_req), 32'h0);
    wr_lat(0, 8'h1F);
    step();
    wr_glb(32'h1);
    set_evt(0, 5'h01);
    chk("R9 gated by disable", 32'(msi_req), 32'h0);
    wr_glb(32'h0);
    chk("R9 pulse on enable", 32'(msi_req), 32'h1);
    wr_lat(0, 8'h1F);
    msi_en = 1'b0;

    // R10 out-of-range slot writes
    for (int s = NS; s < 32; s++) begin
      wr_msk(s, 8'h00);
      wr_lat(s, 8'hFF);
    end
    set_evt(3, 5'h08);
    for (int s = NS; s < 32; s++) wr_lat(s, 8'hFF);
    for (int s = 0; s < NS; s++) begin
      chk("R10 mask intact", 32'(msk_of(s)), (s == 0) ? 32'h00 : 32'h7F);
    end
    chk("R10 latch intact", 32'(lat_of(3)), 32'h08);
    chk("R10 locator", locator, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule